// File: doc/BRIEF.md
# Phase-Measuring Clock-Crossing FIFO

This block carries data words from a write clock domain into a read clock domain through a small dual-clock FIFO. It serves either direction of a link: from the user side toward the line side, or back. Write and read pointers cross between the domains as Gray code through synchronizer chains. A full flag on the write side and a data-available flag on the read side stop overflow and underflow.

A third clock, the measurement clock, drives a latency meter. A designer usually sets this clock slightly off the user clock, so that N of its periods span M user periods and M/N is close to 1. On every measurement edge the meter takes two samples. The first is the XOR of two divide-by-two toggles, one running in the write domain and one in the read domain; this is the phase sample. The second is the synchronized fill level. Each sample goes into its own accumulator. After N measurement edges, where N comes from a window-length input, both sums are published, a one-cycle strobe marks the update, and the accumulators clear. The published fill sum is the latency figure. The published phase sum gives the relative phase of the two clocks at sub-cycle resolution.

If the measurement clock is the user clock itself, the meter still works, at one-cycle precision. If the measurement clock is held low, the meter freezes while the FIFO keeps moving data.

Top module: `phase_fifo_meter`

## Requirements
- R1: Words accepted on the write port leave the read port unchanged and in the order they were written.
- R2: `wr_full` is high while the write side sees DEPTH words stored. A write offered while `wr_full` is high is dropped, and the stored words are not disturbed.
- R3: `rd_valid` is low when the FIFO is empty. A `rd_ready` pulse while it is low removes nothing, and a word written later still comes out correctly.
- R4: The window length is `win_len` measurement cycles, and a value of 0 acts as 1. `acc_strobe_o` is high for exactly one measurement cycle in each window, so with `win_len`=4 it is high once every fourth cycle, and with `win_len`=0 it is high on every cycle.
- R5: `phase_acc_o` is the sum over the window of the XOR of the synchronized write-domain and read-domain toggles. With the write and read clocks identical and reset together, it is 0. With the read clock stopped and the measurement clock equal to the write clock, a window of 4 gives 2.
- R6: `latency_o` is the sum over the window of the synchronized fill level (write count minus read count). A steady fill F over a window of N gives F*N.
- R7: `phase_acc_o` and `latency_o` change only together with a strobe. While the measurement clock is held at 0 they keep their last values, no strobe appears, and the FIFO keeps transferring data.
- R8: While reset is held, `phase_acc_o`, `latency_o`, `acc_strobe_o`, `rd_valid` and `wr_full` are all 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_arst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_data | input | DW | Word to store |
| wr_valid | input | 1 | Store `wr_data` on this edge when not full |
| wr_full | output | 1 | FIFO holds DEPTH words as seen by the writer |
| rd_clk | input | 1 | Read-domain clock |
| rd_arst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_data | output | DW | Oldest stored word (show-ahead) |
| rd_valid | output | 1 | `rd_data` holds a stored word |
| rd_ready | input | 1 | Consume the current word on this edge |
| meas_clk | input | 1 | Measurement clock; may be held at 0 |
| meas_arst_n | input | 1 | Measurement-domain asynchronous reset, active low |
| win_len | input | NW | Window length in measurement cycles (0 acts as 1) |
| phase_acc_o | output | ACC_W | Phase samples summed over the last window |
| acc_strobe_o | output | 1 | One-cycle pulse when the results update |
| latency_o | output | ACC_W | Fill-level samples summed over the last window |

## Verification
`wr_full` reacts in the same write cycle that fills the last slot. `rd_valid` rises only after the write pointer has passed through the synchronizer chain. A fill change reaches the meter after two write-side edges plus two measurement edges. For these reasons the bench waits at least twenty cycles after its last write before it reads a latency result. It then skips the first strobe and checks the results of the second, whose whole window falls after the pointers have settled. Strobe spacing is checked edge by edge: after a sampled strobe, the bench expects exactly `win_len`-1 low samples before the next high one. All outputs are sampled on the falling clock edge, half a period after the registers update.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
   localparam int unsigned SYNC_MIN_STAGES = 2;

   // Bits needed to hold a window of (2**n_w - 1) samples of ptr_w bits each
   function automatic int unsigned acc_bits_needed(int unsigned ptr_w, int unsigned n_w);
      return ptr_w + n_w;
   endfunction
endpackage

// File: rtl/pfm_rst_sync.sv
module pfm_rst_sync (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [1:0] chain;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= 2'b00;
      else         chain <= {chain[0], 1'b1};
   end
   assign rst_n = chain[1];
endmodule

// File: rtl/pfm_sync.sv
module pfm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end
   assign q = stg[STAGES-1];
endmodule

// File: rtl/pfm_g2b.sv
module pfm_g2b #(
   parameter int W = 4
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin[i] = ^gray[W-1:i];
   end
endmodule

// File: rtl/pfm_meas.sv
module pfm_meas #(
   parameter int PW          = 4,
   parameter int NW          = 8,
   parameter int ACC_W       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    win_len,
   input  logic [PW-1:0]    wgray,
   input  logic [PW-1:0]    rgray,
   input  logic             wtgl,
   input  logic             rtgl,
   output logic [ACC_W-1:0] phase_o,
   output logic             strobe_o,
   output logic [ACC_W-1:0] lat_o
);
   logic [PW-1:0]    wg_m, rg_m, wb_m, rb_m, fill;
   logic [1:0]       tgl_m;
   logic [NW-1:0]    eff, cnt;
   logic             last, ph_bit;
   logic [ACC_W-1:0] pacc, lacc, pacc_nx, lacc_nx;

   pfm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (.clk(clk), .rst_n(rst_n), .d(wgray), .q(wg_m));
   pfm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (.clk(clk), .rst_n(rst_n), .d(rgray), .q(rg_m));
   pfm_sync #(.W(2),  .STAGES(SYNC_STAGES)) u_tsync (.clk(clk), .rst_n(rst_n), .d({rtgl, wtgl}), .q(tgl_m));
   pfm_g2b  #(.W(PW)) u_wb (.gray(wg_m), .bin(wb_m));
   pfm_g2b  #(.W(PW)) u_rb (.gray(rg_m), .bin(rb_m));

   assign fill    = wb_m - rb_m;
   assign ph_bit  = tgl_m[0] ^ tgl_m[1];
   assign eff     = (win_len == '0) ? NW'(1) : win_len;
   assign last    = (cnt >= eff - NW'(1));
   assign pacc_nx = pacc + ACC_W'(ph_bit);
   assign lacc_nx = lacc + ACC_W'(fill);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; pacc <= '0; lacc <= '0;
         phase_o <= '0; lat_o <= '0; strobe_o <= 1'b0;
      end else begin
         strobe_o <= last;
         if (last) begin
            phase_o <= pacc_nx;
            lat_o   <= lacc_nx;
            pacc    <= '0;
            lacc    <= '0;
            cnt     <= '0;
         end else begin
            pacc <= pacc_nx;
            lacc <= lacc_nx;
            cnt  <= cnt + NW'(1);
         end
      end
   end

   // R4: a strobe in a window longer than one cycle is followed by a low cycle
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && eff > NW'(1)) |=> !strobe_o);
   // R7: results move only together with the strobe
   assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> ($stable(phase_o) && $stable(lat_o)));
   // R5: at most one phase sample per elapsed cycle of the window
   assert_phase_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pacc <= ACC_W'(cnt));
endmodule

// File: rtl/phase_fifo_meter.sv
module phase_fifo_meter
   import pfm_pkg::*;
#(
   parameter int DW          = 16,
   parameter int DEPTH       = 8,
   parameter int NW          = 8,
   parameter int ACC_W       = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             wr_arst_n,
   input  logic [DW-1:0]    wr_data,
   input  logic             wr_valid,
   output logic             wr_full,
   input  logic             rd_clk,
   input  logic             rd_arst_n,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   input  logic             meas_clk,
   input  logic             meas_arst_n,
   input  logic [NW-1:0]    win_len,
   output logic [ACC_W-1:0] phase_acc_o,
   output logic             acc_strobe_o,
   output logic [ACC_W-1:0] latency_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("DEPTH must be a power of two >= 2");
      assert (SYNC_STAGES >= int'(SYNC_MIN_STAGES)) else $error("SYNC_STAGES too small");
      assert (ACC_W >= int'(acc_bits_needed(PW, NW))) else $error("ACC_W too narrow");
   end

   logic wr_rst_n, rd_rst_n, m_rst_n;
   pfm_rst_sync u_wrst (.clk(wr_clk),   .arst_n(wr_arst_n),   .rst_n(wr_rst_n));
   pfm_rst_sync u_rrst (.clk(rd_clk),   .arst_n(rd_arst_n),   .rst_n(rd_rst_n));
   pfm_rst_sync u_mrst (.clk(meas_clk), .arst_n(meas_arst_n), .rst_n(m_rst_n));

   logic [DW-1:0] mem [DEPTH];

   // ---------------- write domain ----------------
   logic [PW-1:0] wbin, wbin_nx, wgray, rgray_w, rbin_w, fill_w;
   logic          wtgl, wr_en;

   pfm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w));
   pfm_g2b  #(.W(PW)) u_rbw (.gray(rgray_w), .bin(rbin_w));

   assign fill_w  = wbin - rbin_w;
   assign wr_full = (fill_w == FULL_LVL);
   assign wr_en   = wr_valid & ~wr_full;
   assign wbin_nx = wbin + PW'(1);

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin <= '0; wgray <= '0; wtgl <= 1'b0;
      end else begin
         wtgl <= ~wtgl;
         if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
         end
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
   end

   assert_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && wr_full) |=> $stable(wbin));
   assert_fill_bound_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      fill_w <= FULL_LVL);

   // ---------------- read domain ----------------
   logic [PW-1:0] rbin, rbin_nx, rgray, wgray_r;
   logic          rtgl, rd_en;

   pfm_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r));

   assign rd_valid = (rgray != wgray_r);
   assign rd_en    = rd_ready & rd_valid;
   assign rbin_nx  = rbin + PW'(1);
   assign rd_data  = mem[rbin[AW-1:0]];

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rbin <= '0; rgray <= '0; rtgl <= 1'b0;
      end else begin
         rtgl <= ~rtgl;
         if (rd_en) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
         end
      end
   end

   assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_ready && !rd_valid) |=> $stable(rbin));

   // ---------------- measurement domain ----------------
   pfm_meas #(.PW(PW), .NW(NW), .ACC_W(ACC_W), .SYNC_STAGES(SYNC_STAGES)) u_meas (
      .clk(meas_clk), .rst_n(m_rst_n), .win_len(win_len),
      .wgray(wgray), .rgray(rgray), .wtgl(wtgl), .rtgl(rtgl),
      .phase_o(phase_acc_o), .strobe_o(acc_strobe_o), .lat_o(latency_o));
endmodule

// File: tb/phase_fifo_meter_test.sv
`timescale 1ns/1ps
module phase_fifo_meter_test;
   localparam int DW = 16, DEPTH = 8, NW = 8, ACC_W = 20;

   logic clk = 1'b0, rd_en = 1'b1, m_en = 1'b1, arst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_valid = 1'b0, rd_ready = 1'b0;
   logic [NW-1:0] win_len = 8'd4;
   logic wr_full, rd_valid, acc_strobe_o;
   logic [DW-1:0] rd_data;
   logic [ACC_W-1:0] phase_acc_o, latency_o;
   logic rd_clk, meas_clk;
   int nvec = 0, nbad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   assign rd_clk   = clk & rd_en;
   assign meas_clk = clk & m_en;

   phase_fifo_meter #(.DW(DW), .DEPTH(DEPTH), .NW(NW), .ACC_W(ACC_W)) uut (
      .wr_clk(clk), .wr_arst_n(arst_n), .wr_data(wr_data), .wr_valid(wr_valid), .wr_full(wr_full),
      .rd_clk(rd_clk), .rd_arst_n(arst_n), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .meas_clk(meas_clk), .meas_arst_n(arst_n), .win_len(win_len),
      .phase_acc_o(phase_acc_o), .acc_strobe_o(acc_strobe_o), .latency_o(latency_o));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rd_en = 1'b1; m_en = 1'b1; wr_valid = 1'b0; rd_ready = 1'b0;
      arst_n = 1'b0;
      cycles(3);
      arst_n = 1'b1;
      cycles(4);
   endtask

   task automatic push(input logic [DW-1:0] d);
      wr_data = d; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pop(input logic [DW-1:0] exp, input string req);
      chk(rd_valid == 1'b1, req, rd_valid, 1);
      chk(rd_data == exp, req, rd_data, exp);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   task automatic wait_strobe(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (acc_strobe_o) begin seen = 1'b1; break; end
      end
   endtask

   // R8: everything at zero while reset is held
   task automatic t_reset();
      @(negedge clk);
      arst_n = 1'b0;
      cycles(2);
      chk(phase_acc_o == 0, "R8 phase", phase_acc_o, 0);
      chk(latency_o == 0, "R8 latency", latency_o, 0);
      chk(acc_strobe_o == 0, "R8 strobe", acc_strobe_o, 0);
      chk(rd_valid == 0, "R8 rd_valid", rd_valid, 0);
      chk(wr_full == 0, "R8 wr_full", wr_full, 0);
      do_reset();
   endtask

   // R1 ordering, R3 empty handling
   task automatic t_order();
      do_reset();
      for (int i = 0; i < 6; i++) push(DW'(i * 17 + 3));
      cycles(5);
      for (int i = 0; i < 6; i++) pop(DW'(i * 17 + 3), "R1 order");
      cycles(2);
      chk(rd_valid == 0, "R3 empty", rd_valid, 0);
      rd_ready = 1'b1; cycles(3); rd_ready = 1'b0;
      chk(rd_valid == 0, "R3 empty after pop attempt", rd_valid, 0);
      push(16'hBEEF);
      cycles(5);
      pop(16'hBEEF, "R3 word after underflow attempt");
   endtask

   // R5 in-phase clocks give zero phase; R6 empty FIFO gives zero latency
   task automatic t_phase_equal();
      bit s;
      do_reset();
      win_len = 8'd4;
      wait_strobe(s); wait_strobe(s);
      chk(s, "R4 strobe seen", s, 1);
      chk(phase_acc_o == 0, "R5 in-phase", phase_acc_o, 0);
      chk(latency_o == 0, "R6 empty fill", latency_o, 0);
   endtask

   // R4 strobe spacing and zero window
   task automatic t_window();
      bit s;
      win_len = 8'd4;
      wait_strobe(s); wait_strobe(s);
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk(acc_strobe_o == 0, "R4 gap in window of 4", acc_strobe_o, 0);
      end
      @(negedge clk);
      chk(acc_strobe_o == 1, "R4 strobe after 4", acc_strobe_o, 1);
      win_len = 8'd0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(acc_strobe_o == 1, "R4 zero acts as one", acc_strobe_o, 1);
      end
      win_len = 8'd4;
   endtask

   // R5 stopped read clock, R6 fill times window, R2 full handling
   task automatic t_lat_full();
      bit s;
      do_reset();
      rd_en = 1'b0;
      win_len = 8'd4;
      for (int i = 0; i < 5; i++) push(DW'(16'hA0 + i));
      cycles(20);
      wait_strobe(s); wait_strobe(s);
      chk(latency_o == 20, "R6 fill 5 window 4", latency_o, 20);
      chk(phase_acc_o == 2, "R5 read clock stopped", phase_acc_o, 2);
      for (int i = 0; i < 5; i++) push(DW'(16'h100 + i));
      chk(wr_full == 1, "R2 full at depth", wr_full, 1);
      win_len = 8'd1;
      cycles(10);
      wait_strobe(s);
      chk(latency_o == 8, "R6 fill 8 window 1", latency_o, 8);
      rd_en = 1'b1;
      cycles(2);
      for (int i = 0; i < 5; i++) pop(DW'(16'hA0 + i), "R2 stored words intact");
      for (int i = 0; i < 3; i++) pop(DW'(16'h100 + i), "R2 accepted words");
      cycles(3);
      chk(rd_valid == 0, "R2 dropped words absent", rd_valid, 0);
   endtask

   // R7 held measurement clock
   task automatic t_hold();
      bit s;
      logic [ACC_W-1:0] ph, lt;
      win_len = 8'd3;
      wait_strobe(s);
      @(negedge clk);
      ph = phase_acc_o; lt = latency_o;
      m_en = 1'b0;
      push(16'h0055); push(16'h00AA);
      cycles(5);
      pop(16'h0055, "R7 data while meter frozen");
      pop(16'h00AA, "R7 data while meter frozen");
      cycles(30);
      chk(phase_acc_o == ph, "R7 phase held", phase_acc_o, ph);
      chk(latency_o == lt, "R7 latency held", latency_o, lt);
      chk(acc_strobe_o == 0, "R7 no strobe when frozen", acc_strobe_o, 0);
      m_en = 1'b1;
      wait_strobe(s);
      chk(s, "R7 meter resumes", s, 1);
   endtask

   initial begin
      t_reset();
      t_order();
      t_phase_equal();
      t_window();
      t_lat_full();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         nvec++; nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule